// File: doc/BRIEF.md
# Machine-Cycle Watchdog Timer with Power-Down Gating

This block is a watchdog for a small microcontroller core. It counts machine cycles. A machine cycle is a fixed number of oscillator clocks, set by a prescaler. If software fails to service the watchdog before the count reaches a programmable limit, the block raises a device-reset pulse of fixed length. The limit is one less than a power of two. A 3-bit select field in a program register picks the exponent, starting from a base exponent. Each step of the field doubles the timeout.

Software services, or "feeds", the watchdog with a two-write key sequence to a separate service register. The first valid feed also starts the watchdog. A changed select value takes effect only at the next feed. The compare limit therefore never moves while a count is in progress.

The core reports power-down status, and the block also watches the level-triggered external wake-up interrupt line. During power-down the count is frozen. When a wake-up comes through that interrupt, the count stays frozen until the interrupt line returns high. Idle mode does not stop the count, so an idle core must still feed the watchdog.

Top module: `mc_watchdog`

## Requirements
- R1: The program register sits at address 8'hA7. A write there stores wdata bits 2..0 as the select value, and bits 7..3 are discarded. A read of that address returns {5'b0, select} on reg_rdata one clock after the address is presented. Any other address reads as zero.
- R2: After reset, the select value is 0, the watchdog is stopped, reg_rdata is 0 and wdt_rst_o is low.
- R3: A feed is a write of 8'h1E to the service address 8'hA6, followed by a write of 8'hE1 to the same address as the very next write on the port. Any other write in between, to either address, cancels the sequence. A lone 8'hE1 or a broken sequence changes nothing.
- R4: After a feed, with power-down low throughout, wdt_rst_o rises exactly (2^(BASE_EXP+S)-1) x CLKS_PER_MC clocks later. S is the select value latched at that feed.
- R5: A select write made while the watchdog runs does not change the current timeout. It applies from the next feed.
- R6: wdt_rst_o stays high for exactly PULSE_CLKS clocks. Afterwards the watchdog is stopped and raises no further pulse until it is fed again.
- R7: A feed while the watchdog runs restarts the full timeout from zero.
- R8: While pd_i is high, the count does not advance.
- R9: If wake_int_n is low while pd_i is high, the count stays frozen after pd_i falls, for as long as wake_int_n stays low. It advances again in the first clock in which wake_int_n is high.
- R10: While stopped, the block never raises wdt_rst_o, whatever the power-mode inputs do.
- R11: A feed that arrives during the reset pulse is ignored. The pulse keeps its full length, and the watchdog is stopped afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| pd_i | input | 1 | Core is in power-down (oscillator stopped) |
| wake_int_n | input | 1 | Level-triggered external wake-up interrupt, active low |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Registered read data |
| wdt_rst_o | output | 1 | Device reset pulse, registered |

## Verification
The bench builds the block with CLKS_PER_MC=2, BASE_EXP=3 and PULSE_CLKS=5. With these values the shortest timeout is 14 clocks and the longest (select 7) is 2046 clocks. Both extreme select values are therefore measured to the exact clock within a short run. The small prescaler keeps off-by-one errors in the machine-cycle tick visible. The short pulse lets the bench observe a feed landing in the middle of a pulse, and the quiet period after the pulse, in a few dozen clocks. Freeze and interrupt-hold windows are timed against a clock-by-clock reference model.

// File: rtl/mc_wdt_pkg.sv
package mc_wdt_pkg;
  localparam logic [7:0] FEED_KEY_A = 8'h1E;
  localparam logic [7:0] FEED_KEY_B = 8'hE1;

  typedef enum logic [1:0] {
    WD_OFF  = 2'd0,
    WD_RUN  = 2'd1,
    WD_FIRE = 2'd2
  } wd_state_e;
endpackage

// File: rtl/mc_wdt_regs.sv
module mc_wdt_regs
  import mc_wdt_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int SEL_W = 3,
  parameter logic [ADDR_W-1:0] PRG_ADDR = 8'hA7,
  parameter logic [ADDR_W-1:0] FEED_ADDR = 8'hA6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  output logic [SEL_W-1:0]  sel_act,
  output logic              feed
);
  logic [SEL_W-1:0] sel_q;
  logic             primed_q;
  logic             feed_wr;

  assign feed_wr = we && (addr == FEED_ADDR);
  assign feed    = feed_wr && primed_q && (wdata == FEED_KEY_B);

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q    <= '0;
      sel_act  <= '0;
      primed_q <= 1'b0;
      rdata    <= '0;
    end else begin
      if (we && (addr == PRG_ADDR)) sel_q <= wdata[SEL_W-1:0];
      if (we) primed_q <= feed_wr && (wdata == FEED_KEY_A);
      if (feed) sel_act <= sel_q;
      rdata <= (addr == PRG_ADDR) ? {{(8-SEL_W){1'b0}}, sel_q} : 8'h00;
    end
  end
endmodule

// File: rtl/mc_wdt_pmgate.sv
module mc_wdt_pmgate (
  input  logic clk,
  input  logic rst,
  input  logic pd_i,
  input  logic wake_int_n,
  output logic freeze
);
  logic hold_q;

  assign freeze = pd_i || (hold_q && !wake_int_n);

  always_ff @(posedge clk) begin
    if (rst) hold_q <= 1'b0;
    else     hold_q <= !wake_int_n && (pd_i || hold_q);
  end
endmodule

// File: rtl/mc_wdt_prescale.sv
module mc_wdt_prescale #(
  parameter int CLKS_PER_MC = 12
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic clr,
  output logic tick
);
  localparam int PRE_W = $clog2(CLKS_PER_MC + 1);
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(CLKS_PER_MC - 1);

  logic [PRE_W-1:0] pre_q;

  assign tick = en && !clr && (pre_q == PRE_LAST);

  always_ff @(posedge clk) begin
    if (rst || clr)  pre_q <= '0;
    else if (en)     pre_q <= (pre_q == PRE_LAST) ? '0 : pre_q + 1'b1;
  end
endmodule

// File: rtl/mc_wdt_count.sv
module mc_wdt_count
  import mc_wdt_pkg::*;
#(
  parameter int BASE_EXP = 14,
  parameter int SEL_W = 3,
  parameter int PULSE_CLKS = 96,
  parameter int CNT_W = BASE_EXP + (1 << SEL_W) - 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             feed,
  input  logic             tick,
  input  logic [SEL_W-1:0] sel_act,
  output logic [CNT_W-1:0] mc_cnt,
  output logic             running,
  output logic             rst_o
);
  localparam int PCNT_W = $clog2(PULSE_CLKS + 1);
  localparam logic [PCNT_W-1:0] PULSE_LAST = PCNT_W'(PULSE_CLKS - 1);

  wd_state_e         state_q;
  logic [PCNT_W-1:0] pcnt_q;
  logic [CNT_W:0]    limit_w;
  logic [CNT_W-1:0]  last_cnt;

  assign limit_w  = ((CNT_W+1)'(1) << (BASE_EXP + int'(sel_act))) - (CNT_W+1)'(1);
  assign last_cnt = limit_w[CNT_W-1:0] - CNT_W'(1);
  assign running  = (state_q == WD_RUN);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= WD_OFF;
      mc_cnt  <= '0;
      pcnt_q  <= '0;
      rst_o   <= 1'b0;
    end else begin
      unique case (state_q)
        WD_OFF: begin
          if (feed) begin
            state_q <= WD_RUN;
            mc_cnt  <= '0;
          end
        end
        WD_RUN: begin
          if (feed) begin
            mc_cnt <= '0;
          end else if (tick) begin
            if (mc_cnt == last_cnt) begin
              state_q <= WD_FIRE;
              mc_cnt  <= '0;
              pcnt_q  <= '0;
              rst_o   <= 1'b1;
            end else begin
              mc_cnt <= mc_cnt + 1'b1;
            end
          end
        end
        WD_FIRE: begin
          if (pcnt_q == PULSE_LAST) begin
            state_q <= WD_OFF;
            rst_o   <= 1'b0;
          end else begin
            pcnt_q <= pcnt_q + 1'b1;
          end
        end
        default: state_q <= WD_OFF;
      endcase
    end
  end
endmodule

// File: rtl/mc_watchdog.sv
module mc_watchdog #(
  parameter int CLKS_PER_MC = 12,
  parameter int BASE_EXP = 14,
  parameter int SEL_W = 3,
  parameter int PULSE_CLKS = 96,
  parameter logic [7:0] PRG_ADDR = 8'hA7,
  parameter logic [7:0] FEED_ADDR = 8'hA6
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       pd_i,
  input  logic       wake_int_n,
  input  logic       reg_we,
  input  logic [7:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       wdt_rst_o
);
  localparam int CNT_W = BASE_EXP + (1 << SEL_W) - 1;

  logic [SEL_W-1:0] sel_act;
  logic             feed;
  logic             freeze;
  logic             tick;
  logic             running;
  logic [CNT_W-1:0] mc_cnt;

  mc_wdt_regs #(
    .ADDR_W(8), .SEL_W(SEL_W), .PRG_ADDR(PRG_ADDR), .FEED_ADDR(FEED_ADDR)
  ) u_regs (
    .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .rdata(reg_rdata), .sel_act(sel_act), .feed(feed)
  );

  mc_wdt_pmgate u_pm (
    .clk(clk), .rst(rst), .pd_i(pd_i), .wake_int_n(wake_int_n), .freeze(freeze)
  );

  mc_wdt_prescale #(.CLKS_PER_MC(CLKS_PER_MC)) u_pre (
    .clk(clk), .rst(rst), .en(running && !freeze), .clr(feed), .tick(tick)
  );

  mc_wdt_count #(
    .BASE_EXP(BASE_EXP), .SEL_W(SEL_W), .PULSE_CLKS(PULSE_CLKS), .CNT_W(CNT_W)
  ) u_cnt (
    .clk(clk), .rst(rst), .feed(feed), .tick(tick), .sel_act(sel_act),
    .mc_cnt(mc_cnt), .running(running), .rst_o(wdt_rst_o)
  );
endmodule

// File: rtl/mc_watchdog_chk.sv
module mc_watchdog_chk #(
  parameter int CNT_W = 21
) (
  input logic             clk,
  input logic             rst,
  input logic             pd_i,
  input logic             wake_int_n,
  input logic             feed,
  input logic             running,
  input logic [CNT_W-1:0] mc_cnt,
  input logic [7:0]       reg_rdata,
  input logic             wdt_rst_o
);
  // R1: upper read bits are always zero
  a_r1_rsvd_zero: assert property (@(posedge clk) disable iff (rst)
    reg_rdata[7:3] == 5'b0);

  // R6: a pulse lasts more than one clock and is followed by a quiet clock
  a_r6_pulse_holds: assert property (@(posedge clk) disable iff (rst)
    $rose(wdt_rst_o) |=> wdt_rst_o);
  a_r6_no_rearm: assert property (@(posedge clk) disable iff (rst)
    $fell(wdt_rst_o) |=> !wdt_rst_o);

  // R8: power-down freezes the running count
  a_r8_pd_freeze: assert property (@(posedge clk) disable iff (rst)
    (pd_i && running && !feed) |=> $stable(mc_cnt));

  // R9: interrupt held low after a power-down wake keeps the count frozen
  a_r9_wake_hold: assert property (@(posedge clk) disable iff (rst)
    ($past(pd_i) && $past(!wake_int_n) && !wake_int_n && running && !feed)
      |=> $stable(mc_cnt));

  // R10: a stopped watchdog never counts and never fires anew
  a_r10_stopped_quiet: assert property (@(posedge clk) disable iff (rst)
    (!running && !wdt_rst_o) |=> !$rose(wdt_rst_o));
endmodule

bind mc_watchdog mc_watchdog_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .pd_i(pd_i), .wake_int_n(wake_int_n), .feed(feed),
  .running(running), .mc_cnt(mc_cnt), .reg_rdata(reg_rdata), .wdt_rst_o(wdt_rst_o)
);

// File: tb/test_mc_watchdog.sv
module test_mc_watchdog;
  localparam int K = 2;
  localparam int E = 3;
  localparam int L = 5;
  localparam logic [7:0] PRG = 8'hA7;
  localparam logic [7:0] FEA = 8'hA6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pd = 1'b0;
  logic int_n = 1'b1;
  logic we = 1'b0;
  logic [7:0] addr = 8'h00;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic wrst;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  mc_watchdog #(.CLKS_PER_MC(K), .BASE_EXP(E), .SEL_W(3), .PULSE_CLKS(L)) i_mc_watchdog (
    .clk(clk), .rst(rst), .pd_i(pd), .wake_int_n(int_n), .reg_we(we),
    .reg_addr(addr), .reg_wdata(wdata), .reg_rdata(rdata), .wdt_rst_o(wrst)
  );

  // reference model
  int  m_sel, m_act, m_el, m_pc;
  bit  m_armed, m_fire, m_primed, m_hold, m_rst;
  logic [7:0] m_rd;

  always @(posedge clk) begin
    if (rst) begin
      m_sel = 0; m_act = 0; m_el = 0; m_pc = 0;
      m_armed = 0; m_fire = 0; m_primed = 0; m_hold = 0; m_rst = 0; m_rd = 8'h00;
    end else begin
      bit fd, frz;
      fd  = we && addr == FEA && wdata == 8'hE1 && m_primed;
      frz = pd || (m_hold && !int_n);
      m_rd = (addr == PRG) ? 8'(m_sel) : 8'h00;
      if (we) m_primed = (addr == FEA) && (wdata == 8'h1E);
      m_hold = !int_n && (pd || m_hold);
      if (m_fire) begin
        m_pc++;
        if (m_pc == L) begin m_fire = 0; m_rst = 0; end
      end else if (fd) begin
        m_armed = 1; m_el = 0; m_act = m_sel;
      end else if (m_armed && !frz) begin
        m_el++;
        if (m_el == ((1 << (E + m_act)) - 1) * K) begin
          m_fire = 1; m_rst = 1; m_pc = 0; m_armed = 0;
        end
      end
      if (fd && m_fire) m_act = m_sel;
      if (we && addr == PRG) m_sel = int'(wdata[2:0]);
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      n_chk++;
      if (wrst !== m_rst) begin
        n_fail++;
        $display("FAIL R4 model compare wdt_rst_o: actual %0b expected %0b at %0t", wrst, m_rst, $time);
      end
      n_chk++;
      if (rdata !== m_rd) begin
        n_fail++;
        $display("FAIL R1 model compare reg_rdata: actual %h expected %h at %0t", rdata, m_rd, $time);
      end
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0; addr = 8'h00;
  endtask

  task automatic feed();
    wr(FEA, 8'h1E);
    wr(FEA, 8'hE1);
  endtask

  task automatic clocks_to_fire(output int n);
    n = 0;
    while (!wrst && n < 5000) begin @(negedge clk); n++; end
  endtask

  task automatic pulse_len(output int n);
    n = 0;
    while (wrst && n < 100) begin n++; @(negedge clk); end
  endtask

  task automatic quiet(input int cyc, input string tag);
    bit seen = 1'b0;
    for (int i = 0; i < cyc; i++) begin @(negedge clk); if (wrst) seen = 1'b1; end
    check(!seen, tag, int'(seen), 0);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired: actual hung expected finished");
    finish_run();
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(wrst == 1'b0, "R2 reset output", int'(wrst), 0);
    check(rdata == 8'h00, "R2 reset rdata", int'(rdata), 0);

    // R1: reserved bits dropped, read after one clock
    wr(PRG, 8'hFA);
    addr = PRG; @(negedge clk);
    check(rdata == 8'h02, "R1 select readback", int'(rdata), 2);
    addr = FEA; @(negedge clk);
    check(rdata == 8'h00, "R1 other address reads zero", int'(rdata), 0);
    wr(PRG, 8'h00);

    // R10: stopped, power modes toggle, no pulse
    pd = 1'b1; int_n = 1'b0; repeat (10) @(negedge clk);
    pd = 1'b0; int_n = 1'b1;
    quiet(40, "R10 stopped stays quiet");

    // R3: broken sequences
    wr(FEA, 8'hE1);
    quiet(40, "R3 lone second key");
    wr(FEA, 8'h1E); wr(FEA, 8'h55); wr(FEA, 8'hE1);
    quiet(40, "R3 wrong middle write");
    wr(FEA, 8'h1E); wr(PRG, 8'h00); wr(FEA, 8'hE1);
    quiet(40, "R3 other-address write between keys");

    // R4 / R6: shortest timeout and pulse
    feed();
    clocks_to_fire(n);
    check(n == 14, "R4 select 0 timeout", n, 14);
    pulse_len(n);
    check(n == L, "R6 pulse length", n, L);
    quiet(60, "R6 stopped after pulse");

    // R5: select change waits for the next feed
    feed();
    wr(PRG, 8'h02);
    clocks_to_fire(n);
    check(n == 13, "R5 old select still used", n, 13);
    pulse_len(n);
    feed();
    clocks_to_fire(n);
    check(n == 62, "R5 new select after feed", n, 62);
    pulse_len(n);
    wr(PRG, 8'h00);

    // R7: refeed restarts
    feed();
    repeat (10) @(negedge clk);
    feed();
    clocks_to_fire(n);
    check(n == 14, "R7 refeed restarts", n, 14);

    // R11: feed in the pulse ignored
    feed();
    pulse_len(n);
    check(n == L - 2, "R11 pulse keeps length", n, L - 2);
    quiet(60, "R11 stays stopped");

    // R4: longest timeout
    wr(PRG, 8'h07);
    feed();
    clocks_to_fire(n);
    check(n == 2046, "R4 select 7 timeout", n, 2046);
    pulse_len(n);
    wr(PRG, 8'h00);

    // R8: power-down freezes
    feed();
    repeat (4) @(negedge clk);
    pd = 1'b1;
    quiet(30, "R8 no pulse in power-down");
    pd = 1'b0;
    clocks_to_fire(n);
    check(n == 10, "R8 remaining after power-down", n, 10);
    pulse_len(n);

    // R9: wake through interrupt holds until release
    feed();
    repeat (4) @(negedge clk);
    pd = 1'b1;
    repeat (6) @(negedge clk);
    int_n = 1'b0;
    repeat (24) @(negedge clk);
    pd = 1'b0;
    quiet(20, "R9 held while interrupt low");
    int_n = 1'b1;
    clocks_to_fire(n);
    check(n == 10, "R9 remaining after release", n, 10);
    pulse_len(n);

    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule